// File: doc/BRIEF.md
# Stream Frame Packetizer

This block takes frames from a 64-bit valid/ready stream that carries destination, identifier and user sideband, and turns them into packets for a link that has no sideband. Each packet begins with one header word. The header word holds a format version, a frame counter, a packet counter and the sideband values. Each packet closes with one tail byte. The tail byte packs the user value of the last data beat together with an end-of-frame flag.

A frame longer than `MAX_BEATS` data beats is cut into several packets. All packets of one frame carry the same frame number, and their packet numbers rise from zero. A `restart` pulse sets the frame counter back to zero. Both stream sides support backpressure. The block holds one registered output beat and handles one frame at a time.

The block assumes the following about its input. Every input beat has all 8 byte lanes valid, except possibly the last beat of a frame. That last beat has its valid lanes packed from lane 0 upward.

Top module: `frame_pktzr`

## Requirements
- R1: The first output beat of every packet is a header with keep 8'hFF and last 0. Its bit fields are: bits 3:0 = 0 (version), 15:4 = frame number, 39:16 = packet number, 47:40 = s_tdest, 55:48 = s_tid, 63:56 = s_tuser. The sideband values are taken from the first input beat of that packet.
- R2: The first frame after reset has frame number 0. Each later frame adds one, and the number wraps from 4095 to 0.
- R3: The first packet of a frame has packet number 0. Each continuation packet of the same frame has the same frame number and a packet number one higher than the packet before it.
- R4: When a packet reaches `MAX_BEATS` data beats without input last, that data beat leaves with last 0. It is followed by a tail beat with keep 8'h01 and last 1. The tail beat's lane 0 holds {1'b0, tuser[6:0]} of the closing beat, and its upper lanes are zero.
- R5: Suppose the last input beat of a frame has k valid lanes, with k < 8. That beat then leaves with the tail byte {1'b1, tuser[6:0]} in lane k, keep = (1<<(k+1))-1, and last 1. Lanes above k are zero.
- R6: Suppose the last input beat of a frame has all 8 lanes valid. It leaves unchanged with last 0. It is followed by a tail beat with keep 8'h01, lane 0 = {1'b1, tuser[6:0]}, upper lanes zero, and last 1.
- R7: After a `restart` pulse, the next frame carries frame number 0.
- R8: m_tdest, m_tid and m_tuser are always zero.
- R9: Under any backpressure on either side, every input byte appears exactly once and in order. While m_tvalid is high and m_tready is low, the output beat does not change.
- R10: s_tready is 0 during reset and while a header or tail beat is being produced. s_tready is 1 only when the output register can take a beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Sets the frame counter to zero |
| s_tdata | input | 64 | Input data |
| s_tkeep | input | 8 | Input byte enables |
| s_tlast | input | 1 | Last beat of input frame |
| s_tdest | input | 8 | Input destination sideband |
| s_tid | input | 8 | Input identifier sideband |
| s_tuser | input | 8 | Input user sideband |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted |
| m_tdata | output | 64 | Output data |
| m_tkeep | output | 8 | Output byte enables |
| m_tlast | output | 1 | Last beat of packet |
| m_tdest | output | 8 | Output destination, always zero |
| m_tid | output | 8 | Output identifier, always zero |
| m_tuser | output | 8 | Output user, always zero |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Output beat taken |

## Verification
Output timing:
- Header: appears on the output one cycle after the edge at which the block, idle and with output space, sees s_tvalid.
- Data beat: appears one cycle after the edge that accepts it.
- Separate tail beat: appears one cycle after its data beat leaves the output register.

The bench does not count cycles to each result. It compares every output beat at its handshake against an expected queue that is built from the requirements. Inputs and m_tready are set at the falling edge. The handshake signals are read a little after that, so the values read are the ones the next rising edge will see.

// File: rtl/pktz_pkg.sv
// Shared constants, state type and helpers for the frame packetizer.
// Assumes a 64-bit beat of 8 byte lanes; header layout is fixed to that width.
package pktz_pkg;
    localparam int LANES   = 8;
    localparam int DATA_W  = LANES * 8;
    localparam int VER_W   = 4;
    localparam int FRAME_W = 12;
    localparam int PKT_W   = 24;
    localparam int LCNT_W  = $clog2(LANES + 1);

    typedef enum logic [1:0] {
        ST_HDR  = 2'd0,
        ST_DATA = 2'd1,
        ST_TAIL = 2'd2
    } pktz_state_e;

    // Number of enabled lanes in a byte-enable vector.
    function automatic logic [LCNT_W-1:0] lane_count(input logic [LANES-1:0] keep);
        logic [LCNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < LANES; i++) begin
            n = n + LCNT_W'(keep[i]);
        end
        return n;
    endfunction
endpackage

// File: rtl/pktz_hdr_fmt.sv
// Builds the header word of a packet from the counters and the sideband of
// the first input beat of that packet. Purely combinational.
module pktz_hdr_fmt
    import pktz_pkg::*;
(
    input  logic [FRAME_W-1:0] frame_num,
    input  logic [PKT_W-1:0]   pkt_num,
    input  logic [7:0]         dest,
    input  logic [7:0]         id,
    input  logic [7:0]         user,
    output logic [DATA_W-1:0]  hdr_word
);
    localparam logic [VER_W-1:0] VERSION = '0;

    // Pack fields: version lowest, then frame, packet, dest, id, user.
    always_comb begin
        hdr_word = {user, id, dest, pkt_num, frame_num, VERSION};
    end
endmodule

// File: rtl/pktz_tail_merge.sv
// Places a tail byte in the first unused lane after the valid bytes of a
// beat and clears lanes above it. Assumes keep is packed from lane 0.
// When all lanes are valid, fits is 0 and the beat passes unchanged.
module pktz_tail_merge
    import pktz_pkg::*;
(
    input  logic [DATA_W-1:0] in_data,
    input  logic [LANES-1:0]  in_keep,
    input  logic [7:0]        tail,
    output logic [DATA_W-1:0] out_data,
    output logic [LANES-1:0]  out_keep,
    output logic              fits
);
    logic [LCNT_W-1:0] used;

    // Count valid lanes; the tail goes at that index.
    always_comb begin
        used = lane_count(in_keep);
        fits = (used < LCNT_W'(LANES));
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Per lane: keep data, insert tail at the boundary, else zero.
        always_comb begin
            if (in_keep[g]) begin
                out_data[8*g +: 8] = in_data[8*g +: 8];
                out_keep[g]        = 1'b1;
            end else if (used == LCNT_W'(g)) begin
                out_data[8*g +: 8] = tail;
                out_keep[g]        = 1'b1;
            end else begin
                out_data[8*g +: 8] = 8'h00;
                out_keep[g]        = 1'b0;
            end
        end
    end
endmodule

// File: rtl/pktz_seq_cnt.sv
// Frame and packet counters. A finished frame advances the frame counter and
// clears the packet counter; a split packet advances the packet counter.
// Restart clears the frame counter and wins over a frame advance.
module pktz_seq_cnt
    import pktz_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               frame_done,
    input  logic               pkt_done,
    output logic [FRAME_W-1:0] frame_num,
    output logic [PKT_W-1:0]   pkt_num
);
    // Frame counter, wraps naturally at its width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_num <= '0;
        end else if (restart) begin
            frame_num <= '0;
        end else if (frame_done) begin
            frame_num <= frame_num + 1'b1;
        end
    end

    // Packet counter within the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_num <= '0;
        end else if (frame_done) begin
            pkt_num <= '0;
        end else if (pkt_done) begin
            pkt_num <= pkt_num + 1'b1;
        end
    end
endmodule

// File: rtl/frame_pktzr.sv
// Frame packetizer top. Sequences header, data and tail beats into one output
// register. Input is accepted only in the data phase when that register can
// load. Assumes non-last input beats are full and keep is packed from lane 0.
module frame_pktzr
    import pktz_pkg::*;
#(
    parameter int MAX_BEATS = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart,
    input  logic [63:0] s_tdata,
    input  logic [7:0]  s_tkeep,
    input  logic        s_tlast,
    input  logic [7:0]  s_tdest,
    input  logic [7:0]  s_tid,
    input  logic [7:0]  s_tuser,
    input  logic        s_tvalid,
    output logic        s_tready,
    output logic [63:0] m_tdata,
    output logic [7:0]  m_tkeep,
    output logic        m_tlast,
    output logic [7:0]  m_tdest,
    output logic [7:0]  m_tid,
    output logic [7:0]  m_tuser,
    output logic        m_tvalid,
    input  logic        m_tready
);
    localparam int BEAT_CW = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;
    localparam logic [BEAT_CW-1:0] LAST_IDX = BEAT_CW'(MAX_BEATS - 1);

    pktz_state_e        state, nxt_state;
    logic [BEAT_CW-1:0] beat_cnt, nxt_cnt;
    logic [7:0]         tail_q, nxt_tail;
    logic               can_load, ld, frame_done, pkt_done;
    logic [DATA_W-1:0]  ld_data, hdr_word, mrg_data;
    logic [LANES-1:0]   ld_keep, mrg_keep;
    logic               ld_last, mrg_fits;
    logic [FRAME_W-1:0] frame_num;
    logic [PKT_W-1:0]   pkt_num;
    logic [7:0]         eof_tail;

    pktz_seq_cnt u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .frame_done (frame_done),
        .pkt_done   (pkt_done),
        .frame_num  (frame_num),
        .pkt_num    (pkt_num)
    );

    pktz_hdr_fmt u_hdr (
        .frame_num (frame_num),
        .pkt_num   (pkt_num),
        .dest      (s_tdest),
        .id        (s_tid),
        .user      (s_tuser),
        .hdr_word  (hdr_word)
    );

    assign eof_tail = {1'b1, s_tuser[6:0]};

    pktz_tail_merge u_merge (
        .in_data  (s_tdata),
        .in_keep  (s_tkeep),
        .tail     (eof_tail),
        .out_data (mrg_data),
        .out_keep (mrg_keep),
        .fits     (mrg_fits)
    );

    // Output register has room this cycle.
    assign can_load = !m_tvalid || m_tready;
    assign s_tready = (state == ST_DATA) && can_load;

    // Sideband does not travel on the link side.
    assign m_tdest = '0;
    assign m_tid   = '0;
    assign m_tuser = '0;

    // Next-state and output-load selection for header, data and tail beats.
    always_comb begin
        nxt_state  = state;
        nxt_cnt    = beat_cnt;
        nxt_tail   = tail_q;
        ld         = 1'b0;
        ld_data    = s_tdata;
        ld_keep    = s_tkeep;
        ld_last    = 1'b0;
        frame_done = 1'b0;
        pkt_done   = 1'b0;
        unique case (state)
            ST_HDR: begin
                if (can_load && s_tvalid) begin
                    ld        = 1'b1;
                    ld_data   = hdr_word;
                    ld_keep   = '1;
                    nxt_cnt   = '0;
                    nxt_state = ST_DATA;
                end
            end
            ST_DATA: begin
                if (s_tvalid && can_load) begin
                    ld      = 1'b1;
                    nxt_cnt = beat_cnt + 1'b1;
                    if (s_tlast) begin
                        ld_data = mrg_data;
                        ld_keep = mrg_keep;
                        if (mrg_fits) begin
                            ld_last    = 1'b1;
                            frame_done = 1'b1;
                            nxt_state  = ST_HDR;
                        end else begin
                            nxt_tail  = eof_tail;
                            nxt_state = ST_TAIL;
                        end
                    end else if (beat_cnt == LAST_IDX) begin
                        nxt_tail  = {1'b0, s_tuser[6:0]};
                        nxt_state = ST_TAIL;
                    end
                end
            end
            ST_TAIL: begin
                if (can_load) begin
                    ld         = 1'b1;
                    ld_data    = {{(DATA_W-8){1'b0}}, tail_q};
                    ld_keep    = LANES'(1);
                    ld_last    = 1'b1;
                    frame_done = tail_q[7];
                    pkt_done   = !tail_q[7];
                    nxt_state  = ST_HDR;
                end
            end
            default: nxt_state = ST_HDR;
        endcase
    end

    // Sequencer state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_HDR;
            beat_cnt <= '0;
            tail_q   <= '0;
        end else begin
            state    <= nxt_state;
            beat_cnt <= nxt_cnt;
            tail_q   <= nxt_tail;
        end
    end

    // Single output beat register with valid/ready hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_tvalid <= 1'b0;
            m_tdata  <= '0;
            m_tkeep  <= '0;
            m_tlast  <= 1'b0;
        end else if (ld) begin
            m_tvalid <= 1'b1;
            m_tdata  <= ld_data;
            m_tkeep  <= ld_keep;
            m_tlast  <= ld_last;
        end else if (m_tready) begin
            m_tvalid <= 1'b0;
        end
    end
endmodule

// File: rtl/frame_pktzr_chk.sv
// Property checker for the frame packetizer, bound to every instance.
// Tracks the position of each output beat within its packet.
module frame_pktzr_chk #(
    parameter int MAX_BEATS = 256
) (
    input logic        clk,
    input logic        rst_n,
    input logic [63:0] m_tdata,
    input logic [7:0]  m_tkeep,
    input logic        m_tlast,
    input logic        m_tvalid,
    input logic        m_tready,
    input logic        s_tready
);
    int pkt_pos;

    // Index of the next output beat within the current packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_pos <= 0;
        end else if (m_tvalid && m_tready) begin
            pkt_pos <= m_tlast ? 0 : pkt_pos + 1;
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tkeep) && $stable(m_tlast)); // R9

    AST_IN_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        s_tready |-> (!m_tvalid || m_tready)); // R10

    AST_KEEP_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> (m_tkeep != 8'h00) && ((m_tkeep & (m_tkeep + 8'd1)) == 8'h00)); // R5

    AST_HDR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && (pkt_pos == 0) |-> (m_tkeep == 8'hFF) && (m_tdata[3:0] == 4'h0) && !m_tlast); // R1

    AST_PKT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && m_tready |-> (pkt_pos <= MAX_BEATS + 1)); // R4
endmodule

bind frame_pktzr frame_pktzr_chk #(.MAX_BEATS(MAX_BEATS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .m_tdata  (m_tdata),
    .m_tkeep  (m_tkeep),
    .m_tlast  (m_tlast),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .s_tready (s_tready)
);

// File: tb/frame_pktzr_tb.sv
module frame_pktzr_tb;
    localparam int MAXB = 4;
    localparam int NV   = 8;
    // {len[8], last-lanes[4], dest[8], id[8], user base[8]}
    localparam logic [35:0] VEC [0:NV-1] = '{
        {8'd1, 4'd1, 8'h11, 8'h21, 8'h05},
        {8'd1, 4'd8, 8'h12, 8'h22, 8'hF0},
        {8'd3, 4'd5, 8'h13, 8'h23, 8'h7E},
        {8'd4, 4'd8, 8'h14, 8'h24, 8'h80},
        {8'd4, 4'd2, 8'h15, 8'h25, 8'h33},
        {8'd5, 4'd7, 8'h16, 8'h26, 8'hC1},
        {8'd8, 4'd8, 8'h17, 8'h27, 8'h44},
        {8'd9, 4'd1, 8'h18, 8'h28, 8'hFD}
    };

    logic        clk = 1'b0;
    logic        rst_n, restart;
    logic [63:0] s_tdata, m_tdata;
    logic [7:0]  s_tkeep, s_tdest, s_tid, s_tuser, m_tkeep, m_tdest, m_tid, m_tuser;
    logic        s_tlast, s_tvalid, s_tready, m_tlast, m_tvalid, m_tready;

    always #5 clk = ~clk;

    frame_pktzr #(.MAX_BEATS(MAXB)) u_dut (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .s_tdata(s_tdata), .s_tkeep(s_tkeep), .s_tlast(s_tlast),
        .s_tdest(s_tdest), .s_tid(s_tid), .s_tuser(s_tuser),
        .s_tvalid(s_tvalid), .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tlast(m_tlast),
        .m_tdest(m_tdest), .m_tid(m_tid), .m_tuser(m_tuser),
        .m_tvalid(m_tvalid), .m_tready(m_tready)
    );

    logic [63:0] iq_d[$];
    logic [7:0]  iq_k[$], iq_dst[$], iq_id[$], iq_u[$];
    logic        iq_l[$];
    logic [63:0] eq_d[$];
    logic [7:0]  eq_k[$];
    logic        eq_l[$];
    int          eq_t[$];

    int n_chk = 0, n_bad = 0, exp_frame = 0, seq = 0;
    bit tmo = 1'b0, run = 1'b0;

    function automatic string tag_name(int t);
        case (t)
            1: return "R1/R3 header";
            2: return "R2 header";
            4: return "R4 split tail";
            5: return "R5 merged tail";
            6: return "R6 separate tail";
            7: return "R7 header after restart";
            default: return "R9 data";
        endcase
    endfunction

    function automatic logic [7:0] pat(int f, int j, int b);
        return 8'((f * 37 + j * 8 + b) & 255);
    endfunction

    task automatic push_out(logic [63:0] d, logic [7:0] k, logic l, int t);
        eq_d.push_back(d); eq_k.push_back(k); eq_l.push_back(l); eq_t.push_back(t);
    endtask

    // Expected output and input beats for one frame, built from R1..R6.
    task automatic add_frame(int len, int k, logic [7:0] dst, logic [7:0] id, logic [7:0] ub, int htag);
        int p, last_idx, nb;
        bit fin;
        logic [63:0] d;
        logic [7:0] u, uf;
        p = 0;
        for (int first = 0; first < len; first += MAXB) begin
            last_idx = (first + MAXB < len) ? first + MAXB - 1 : len - 1;
            fin = (last_idx == len - 1);
            uf = ub + 8'(first);
            push_out({uf, id, dst, 24'(p), 12'(exp_frame), 4'h0}, 8'hFF, 1'b0, htag); // R1 R3
            for (int j = first; j <= last_idx; j++) begin
                d = '0;
                nb = (j == len - 1) ? k : 8;
                for (int b = 0; b < nb; b++) d[8*b +: 8] = pat(seq, j, b);
                u = ub + 8'(j);
                if (j < last_idx) begin
                    push_out(d, 8'hFF, 1'b0, 9);
                end else if (!fin) begin
                    push_out(d, 8'hFF, 1'b0, 9);
                    push_out({56'h0, 1'b0, u[6:0]}, 8'h01, 1'b1, 4); // R4
                end else if (k == 8) begin
                    push_out(d, 8'hFF, 1'b0, 9);
                    push_out({56'h0, 1'b1, u[6:0]}, 8'h01, 1'b1, 6); // R6
                end else begin
                    d[8*k +: 8] = {1'b1, u[6:0]};
                    push_out(d, 8'((1 << (k + 1)) - 1), 1'b1, 5); // R5
                end
            end
            p++;
        end
        for (int j = 0; j < len; j++) begin
            d = '0;
            for (int b = 0; b < 8; b++)
                d[8*b +: 8] = (j < len - 1 || b < k) ? pat(seq, j, b) : 8'hEE;
            iq_d.push_back(d);
            iq_k.push_back((j < len - 1) ? 8'hFF : 8'((1 << k) - 1));
            iq_l.push_back(j == len - 1);
            iq_dst.push_back(dst); iq_id.push_back(id); iq_u.push_back(ub + 8'(j));
        end
        seq++;
        exp_frame = (exp_frame + 1) % 4096; // R2
    endtask

    task automatic check_out();
        n_chk++;
        if (eq_d.size() == 0) begin
            n_bad++;
            $display("FAIL R9 unexpected beat: actual data=%h keep=%h last=%b expected none", m_tdata, m_tkeep, m_tlast);
        end else begin
            if (m_tdata !== eq_d[0] || m_tkeep !== eq_k[0] || m_tlast !== eq_l[0]) begin
                n_bad++;
                $display("FAIL %s: actual data=%h keep=%h last=%b expected data=%h keep=%h last=%b",
                         tag_name(eq_t[0]), m_tdata, m_tkeep, m_tlast, eq_d[0], eq_k[0], eq_l[0]);
            end
            void'(eq_d.pop_front()); void'(eq_k.pop_front());
            void'(eq_l.pop_front()); void'(eq_t.pop_front());
        end
        n_chk++;
        if (m_tdest !== 8'h0 || m_tid !== 8'h0 || m_tuser !== 8'h0) begin
            n_bad++;
            $display("FAIL R8 sideband: actual %h/%h/%h expected 00/00/00", m_tdest, m_tid, m_tuser);
        end
    endtask

    // Stream driver and monitor, active once run is set.
    initial begin
        bit acc;
        acc = 1'b0;
        forever begin
            @(negedge clk);
            if (run) begin
                if (acc) begin
                    void'(iq_d.pop_front()); void'(iq_k.pop_front()); void'(iq_l.pop_front());
                    void'(iq_dst.pop_front()); void'(iq_id.pop_front()); void'(iq_u.pop_front());
                    s_tvalid = 1'b0;
                    acc = 1'b0;
                end
                m_tready = ($urandom % 4) != 0;
                if (!s_tvalid && iq_d.size() > 0 && ($urandom % 4) != 0) begin
                    s_tdata = iq_d[0]; s_tkeep = iq_k[0]; s_tlast = iq_l[0];
                    s_tdest = iq_dst[0]; s_tid = iq_id[0]; s_tuser = iq_u[0];
                    s_tvalid = 1'b1;
                end
                #1;
                if (m_tvalid && m_tready) check_out();
                if (s_tvalid && s_tready) acc = 1'b1;
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        tmo = 1'b1;
    end

    task automatic drain();
        while (!tmo && (iq_d.size() > 0 || s_tvalid || eq_d.size() > 0 || m_tvalid)) begin
            @(negedge clk);
            #3;
        end
    endtask

    initial begin
        rst_n = 1'b0; restart = 1'b0; s_tvalid = 1'b0; m_tready = 1'b0;
        s_tdata = '0; s_tkeep = '0; s_tlast = 1'b0; s_tdest = '0; s_tid = '0; s_tuser = '0;
        repeat (3) @(negedge clk);
        #1;
        n_chk++;
        if (m_tvalid !== 1'b0 || s_tready !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 reset state: actual valid=%b ready=%b expected 0/0", m_tvalid, s_tready);
        end
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++)
            add_frame(int'(VEC[i][35:28]), int'(VEC[i][27:24]), VEC[i][23:16], VEC[i][15:8], VEC[i][7:0], 1);

        // R10: with data offered and space free, the header goes first and input waits.
        @(negedge clk);
        s_tdata = iq_d[0]; s_tkeep = iq_k[0]; s_tlast = iq_l[0];
        s_tdest = iq_dst[0]; s_tid = iq_id[0]; s_tuser = iq_u[0];
        s_tvalid = 1'b1; m_tready = 1'b1;
        #1;
        n_chk++;
        if (s_tready !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 ready during header: actual %b expected 0", s_tready);
        end
        run = 1'b1;
        drain();

        // R7: restart between frames, next frame is number 0.
        @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        exp_frame = 0;
        add_frame(2, 4, 8'h5A, 8'hA5, 8'h9C, 7);
        drain();

        // R2: run the frame counter through its wrap.
        for (int i = 0; i < 4100; i++)
            add_frame(1, 3, 8'(i), 8'(i >> 3), 8'(i * 5), 2);
        drain();

        n_chk++;
        if (tmo) begin
            n_bad++;
            $display("FAIL R9 watchdog: actual pending in=%0d out=%0d expected 0/0", iq_d.size(), eq_d.size());
        end else if (eq_d.size() != 0 || iq_d.size() != 0) begin
            n_bad++;
            $display("FAIL R9 leftover beats: actual in=%0d out=%0d expected 0/0", iq_d.size(), eq_d.size());
        end
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule